// File: doc/BRIEF.md
# Triggered Mixed-Signal Capture Engine

The engine records a combined digital and analog picture of a system at a fixed sample interval. At every sample point it writes one record into an external circular buffer. The record holds two complete 32-bit digital port words and two 8-bit analog channel codes, so any digital line can be inspected once capture has finished. At the same sample point, before the record is written, it evaluates a trigger. The trigger is either the level of one chosen digital line or a rising crossing of analog channel 0 with hysteresis. The address of the record where the trigger fired is kept. After that, a post-trigger countdown decides how many further records are written before the engine stops and raises `done`.

A capture is begun by a one-cycle `start` pulse. The pulse latches the whole trigger and timing configuration, clears the write pointer, the trigger flag and the arming state, and loads the countdown. The engine is a state machine with four states:
- `ST_IDLE`: after reset.
- `ST_SAMPLE`: one cycle per sample point, with the write strobe high.
- `ST_GAP`: the wait cycles between sample points.
- `ST_DONE`: capture complete.

Its transitions are:
- start: any state to `ST_SAMPLE`.
- continue: `ST_SAMPLE` to `ST_GAP`.
- finish: `ST_SAMPLE` to `ST_DONE`.
- next point: `ST_GAP` to `ST_SAMPLE` when the interval timer expires.

Top module: `mscap_engine`

## Requirements
- R1: After reset `mem_we`, `done` and `triggered` are low and `trig_addr` is zero, and no record is written until `start`.
- R2: A `start` pulse sampled on a clock edge makes the very next cycle a sample point writing address 0. It clears `done`, `triggered`, the write pointer and the analog arming state, and this holds from any state, including mid-capture.
- R3: Consecutive sample points (cycles with `mem_we` high) are exactly 24 + `extra_wait` clocks apart, with `mem_we` high for a single cycle each.
- R4: The record written at a sample point is `{port_b, port_a, chan1, chan0}` as seen in that cycle: `port_b` in bits 79:48, `port_a` in 47:16, `chan1` in 15:8 and `chan0` in 7:0.
- R5: The write address starts at 0 and rises by one per sample point, wrapping modulo 2^ADDR_W. Without a trigger, capture continues indefinitely.
- R6: With `trig_src` = 0 (pin trigger), the trigger fires at the first sample point where line `trig_pin` of `{port_b, port_a}` equals `trig_pol`. Indices 0..31 select `port_a` and 32..63 select `port_b`.
- R7: With `trig_src` = 1 (level trigger on `chan0`), the engine arms at a sample where `chan0` is at or below `arm_level`. It then fires at a later sample where `chan0` is at or above `fire_level`. Both comparisons use only bits 7:2, ignoring the two low bits.
- R8: The trigger is evaluated before the point is stored. The firing sample is itself written, `trig_addr` holds that sample's write address, and `triggered` rises after that sample and stays high (with `trig_addr` unchanged) until the next `start`.
- R9: Exactly `post_len` further records are written after the firing sample. `done` then rises, and it stays high with no further writes until the next `start`.
- R10: Trigger source, pin, polarity, levels, post length and extra wait are taken at the `start` edge. Changing those ports during a capture has no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a new capture (one-cycle pulse) |
| trig_src | input | 1 | 0 = digital line trigger, 1 = analog level trigger |
| trig_pin | input | 6 | Index of the trigger line within {port_b, port_a} |
| trig_pol | input | 1 | Line level that fires the pin trigger |
| arm_level | input | 8 | Analog arming threshold (compared on bits 7:2) |
| fire_level | input | 8 | Analog firing threshold (compared on bits 7:2) |
| post_len | input | 8 | Records to store after the firing sample |
| extra_wait | input | 8 | Clocks added to the 24-clock base sample interval |
| port_a | input | 32 | First digital sample word |
| port_b | input | 32 | Second digital sample word |
| chan0 | input | 8 | Analog channel 0 code (also the level trigger source) |
| chan1 | input | 8 | Analog channel 1 code |
| mem_we | output | 1 | Buffer write strobe, high at each sample point |
| mem_addr | output | ADDR_W | Buffer write address |
| mem_wdata | output | 80 | Sample record |
| done | output | 1 | Capture finished |
| triggered | output | 1 | Trigger has fired in this capture |
| trig_addr | output | ADDR_W | Buffer address of the firing sample |

## Verification
An interval timer that is off by one shows up as a shifted `mem_we` strobe at the second sample point, 24 + `extra_wait` clocks after `start`. The bench catches it because it predicts every strobe cycle and every record arithmetically from the input waveforms. A wrong arming or trigger state shows up as a `trig_addr` or a record count that differs from the bench's own trigger model. It appears only when capture ends, so every run is taken to `done` and then held to confirm the buffer stays quiet. A pointer that fails to clear on a restart from the middle of a gap shows at the very first write of the next capture.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_GAP    = 2'd2,
        ST_DONE   = 2'd3
    } cap_state_t;

    typedef enum logic {
        SRC_PIN   = 1'b0,
        SRC_LEVEL = 1'b1
    } trig_src_t;

endpackage

// File: rtl/cap_cfg_latch.sv
`timescale 1ns/1ps
module cap_cfg_latch
    import cap_pkg::*;
#(
    parameter int PIN_W    = 6,
    parameter int LVL_W    = 8,
    parameter int WAIT_W   = 8,
    parameter int DEF_ARM  = 8'h70,
    parameter int DEF_FIRE = 8'h90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              src_i,
    input  logic [PIN_W-1:0]  pin_i,
    input  logic              pol_i,
    input  logic [LVL_W-1:0]  arm_i,
    input  logic [LVL_W-1:0]  fire_i,
    input  logic [WAIT_W-1:0] wait_i,
    output trig_src_t         src_q,
    output logic [PIN_W-1:0]  pin_q,
    output logic              pol_q,
    output logic [LVL_W-1:0]  arm_q,
    output logic [LVL_W-1:0]  fire_q,
    output logic [WAIT_W-1:0] wait_q
);

    // Configuration snapshot taken on the start edge (R10)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_q  <= SRC_PIN;
            pin_q  <= '0;
            pol_q  <= 1'b1;
            arm_q  <= LVL_W'(DEF_ARM);
            fire_q <= LVL_W'(DEF_FIRE);
            wait_q <= '0;
        end else if (load) begin
            src_q  <= trig_src_t'(src_i);
            pin_q  <= pin_i;
            pol_q  <= pol_i;
            arm_q  <= arm_i;
            fire_q <= fire_i;
            wait_q <= wait_i;
        end
    end

endmodule

// File: rtl/cap_trigger.sv
`timescale 1ns/1ps
module cap_trigger
    import cap_pkg::*;
#(
    parameter int DIG_W    = 32,
    parameter int LVL_W    = 8,
    parameter int PIN_W    = 6,
    parameter int CMP_DROP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             sample,
    input  logic             active,
    input  trig_src_t        src,
    input  logic [PIN_W-1:0] pin,
    input  logic             pol,
    input  logic [LVL_W-1:0] arm_lvl,
    input  logic [LVL_W-1:0] fire_lvl,
    input  logic [DIG_W-1:0] dig_a,
    input  logic [DIG_W-1:0] dig_b,
    input  logic [LVL_W-1:0] level,
    output logic             hit
);

    localparam int             LINES    = 2 * DIG_W;
    localparam logic [LVL_W-1:0] LOW_ONES = LVL_W'((1 << CMP_DROP) - 1);
    localparam logic [LVL_W-1:0] CMP_MASK = ~LOW_ONES;

    logic [LINES-1:0] lines;
    logic             line_bit;
    logic [LVL_W-1:0] lvl_m;
    logic [LVL_W-1:0] arm_m;
    logic [LVL_W-1:0] fire_m;
    logic             armed_q;
    logic             below_arm;
    logic             above_fire;

    assign lines    = {dig_b, dig_a};
    assign line_bit = lines[pin];

    // Low code bits are masked out of both level comparisons (R7)
    assign lvl_m      = level & CMP_MASK;
    assign arm_m      = arm_lvl & CMP_MASK;
    assign fire_m     = fire_lvl & CMP_MASK;
    assign below_arm  = (lvl_m <= arm_m);
    assign above_fire = (lvl_m >= fire_m);

    always_comb begin
        hit = 1'b0;
        if (sample) begin
            unique case (src)
                SRC_PIN:   hit = (line_bit == pol);
                SRC_LEVEL: hit = armed_q && above_fire;
            endcase
        end
    end

    // Arming: must see the low side before the high side can fire
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (clear) begin
            armed_q <= 1'b0;
        end else if (sample && active && (src == SRC_LEVEL) && !armed_q && below_arm) begin
            armed_q <= 1'b1;
        end
    end

endmodule

// File: rtl/cap_interval.sv
`timescale 1ns/1ps
module cap_interval #(
    parameter int BASE_PERIOD = 24,
    parameter int WAIT_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              tick,
    input  logic [WAIT_W-1:0] wait_i,
    output logic              expired
);

    localparam int TIMER_W = $clog2(BASE_PERIOD + (1 << WAIT_W)) + 1;
    // The sample cycle itself is one clock of the period, and the gap
    // ends on the cycle where the count reads zero.
    localparam logic [TIMER_W-1:0] GAP_BASE = TIMER_W'(BASE_PERIOD - 2);

    logic [TIMER_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= GAP_BASE + TIMER_W'(wait_i);
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/cap_seq.sv
`timescale 1ns/1ps
module cap_seq
    import cap_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              hit,
    input  logic              gap_done,
    input  logic [CNT_W-1:0]  post_len,
    output logic              sample,
    output logic              gap,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              done,
    output logic              triggered,
    output logic [ADDR_W-1:0] trig_addr
);

    cap_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  rem_q;
    logic              trig_q;
    logic [ADDR_W-1:0] taddr_q;
    logic              trig_now;
    logic              finish;

    assign trig_now = trig_q | hit;
    assign finish   = trig_now && (rem_q == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: start, continue, finish, next point
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SAMPLE;
            end
            ST_SAMPLE: begin
                if (start)       state_d = ST_SAMPLE;
                else if (finish) state_d = ST_DONE;
                else             state_d = ST_GAP;
            end
            ST_GAP: begin
                if (start || gap_done) state_d = ST_SAMPLE;
            end
            ST_DONE: begin
                if (start) state_d = ST_SAMPLE;
            end
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        sample = 1'b0;
        gap    = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SAMPLE: sample = 1'b1;
            ST_GAP:    gap    = 1'b1;
            ST_DONE:   done   = 1'b1;
        endcase
    end

    // Pointer, trigger record and post-trigger countdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q   <= '0;
            rem_q   <= '0;
            trig_q  <= 1'b0;
            taddr_q <= '0;
        end else if (start) begin
            ptr_q   <= '0;
            rem_q   <= post_len;
            trig_q  <= 1'b0;
            taddr_q <= '0;
        end else if (state_q == ST_SAMPLE) begin
            ptr_q <= ptr_q + 1'b1;
            if (!trig_q && hit) begin
                trig_q  <= 1'b1;
                taddr_q <= ptr_q;
            end
            if (trig_now && (rem_q != '0)) begin
                rem_q <= rem_q - 1'b1;
            end
        end
    end

    assign wr_ptr    = ptr_q;
    assign triggered = trig_q;
    assign trig_addr = taddr_q;

endmodule

// File: rtl/mscap_engine.sv
`timescale 1ns/1ps
module mscap_engine
    import cap_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DIG_W       = 32,
    parameter int LVL_W       = 8,
    parameter int CNT_W       = 8,
    parameter int WAIT_W      = 8,
    parameter int BASE_PERIOD = 24,
    parameter int CMP_DROP    = 2,
    parameter int DEF_ARM     = 8'h70,
    parameter int DEF_FIRE    = 8'h90,
    localparam int PIN_W      = $clog2(2 * DIG_W),
    localparam int REC_W      = 2 * DIG_W + 2 * LVL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              trig_src,
    input  logic [PIN_W-1:0]  trig_pin,
    input  logic              trig_pol,
    input  logic [LVL_W-1:0]  arm_level,
    input  logic [LVL_W-1:0]  fire_level,
    input  logic [CNT_W-1:0]  post_len,
    input  logic [WAIT_W-1:0] extra_wait,
    input  logic [DIG_W-1:0]  port_a,
    input  logic [DIG_W-1:0]  port_b,
    input  logic [LVL_W-1:0]  chan0,
    input  logic [LVL_W-1:0]  chan1,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [REC_W-1:0]  mem_wdata,
    output logic              done,
    output logic              triggered,
    output logic [ADDR_W-1:0] trig_addr
);

    trig_src_t         src_q;
    logic [PIN_W-1:0]  pin_q;
    logic              pol_q;
    logic [LVL_W-1:0]  arm_q;
    logic [LVL_W-1:0]  fire_q;
    logic [WAIT_W-1:0] wait_q;
    logic              sample;
    logic              gap;
    logic              hit;
    logic              gap_done;

    cap_cfg_latch #(
        .PIN_W    (PIN_W),
        .LVL_W    (LVL_W),
        .WAIT_W   (WAIT_W),
        .DEF_ARM  (DEF_ARM),
        .DEF_FIRE (DEF_FIRE)
    ) cfg_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start),
        .src_i  (trig_src),
        .pin_i  (trig_pin),
        .pol_i  (trig_pol),
        .arm_i  (arm_level),
        .fire_i (fire_level),
        .wait_i (extra_wait),
        .src_q  (src_q),
        .pin_q  (pin_q),
        .pol_q  (pol_q),
        .arm_q  (arm_q),
        .fire_q (fire_q),
        .wait_q (wait_q)
    );

    cap_trigger #(
        .DIG_W    (DIG_W),
        .LVL_W    (LVL_W),
        .PIN_W    (PIN_W),
        .CMP_DROP (CMP_DROP)
    ) trig_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .sample   (sample),
        .active   (!triggered),
        .src      (src_q),
        .pin      (pin_q),
        .pol      (pol_q),
        .arm_lvl  (arm_q),
        .fire_lvl (fire_q),
        .dig_a    (port_a),
        .dig_b    (port_b),
        .level    (chan0),
        .hit      (hit)
    );

    cap_interval #(
        .BASE_PERIOD (BASE_PERIOD),
        .WAIT_W      (WAIT_W)
    ) ivl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sample),
        .tick    (gap),
        .wait_i  (wait_q),
        .expired (gap_done)
    );

    cap_seq #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .hit       (hit),
        .gap_done  (gap_done),
        .post_len  (post_len),
        .sample    (sample),
        .gap       (gap),
        .wr_ptr    (mem_addr),
        .done      (done),
        .triggered (triggered),
        .trig_addr (trig_addr)
    );

    assign mem_we    = sample;
    assign mem_wdata = {port_b, port_a, chan1, chan0};

endmodule

// File: rtl/mscap_engine_chk.sv
`timescale 1ns/1ps
module mscap_engine_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic              triggered,
    input logic [ADDR_W-1:0] trig_addr
);

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (mem_we && (mem_addr == '0) && !done && !triggered));

    assert_single_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !start) |=> !mem_we);

    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !start) |=> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we && !start) |=> $stable(mem_addr));

    assert_trig_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (triggered && !start) |=> (triggered && $stable(trig_addr)));

    assert_done_after_trig_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> triggered);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

endmodule

bind mscap_engine mscap_engine_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .done      (done),
    .triggered (triggered),
    .trig_addr (trig_addr)
);

// File: tb/mscap_engine_tb_top.sv
`timescale 1ns/1ps
module mscap_engine_tb_top;

    localparam int ADDR_W = 4;
    localparam int DEPTH  = 16;
    localparam int BASE   = 24;
    localparam int LOGMAX = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        trig_src = 1'b0;
    logic [5:0]  trig_pin = '0;
    logic        trig_pol = 1'b0;
    logic [7:0]  arm_level = 8'h70;
    logic [7:0]  fire_level = 8'h90;
    logic [7:0]  post_len = '0;
    logic [7:0]  extra_wait = '0;
    logic [31:0] port_a = '0;
    logic [31:0] port_b = '0;
    logic [7:0]  chan0 = '0;
    logic [7:0]  chan1 = '0;
    logic        mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [79:0] mem_wdata;
    logic        done;
    logic        triggered;
    logic [ADDR_W-1:0] trig_addr;

    always #2.5 clk = ~clk;

    mscap_engine #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .trig_src(trig_src),
        .trig_pin(trig_pin), .trig_pol(trig_pol), .arm_level(arm_level),
        .fire_level(fire_level), .post_len(post_len), .extra_wait(extra_wait),
        .port_a(port_a), .port_b(port_b), .chan0(chan0), .chan1(chan1),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .done(done), .triggered(triggered), .trig_addr(trig_addr)
    );

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] cyc = '0;
    int          wave_sel = 0;
    logic [31:0] s1 = '0;
    logic [31:0] s2 = '0;
    logic [31:0] base_cyc = '0;
    int          per_p = BASE;

    logic [31:0]       log_cyc  [LOGMAX];
    logic [ADDR_W-1:0] log_addr [LOGMAX];
    logic [79:0]       log_data [LOGMAX];
    int                log_n = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Stimulus waveforms as pure functions of the cycle number
    function automatic logic [31:0] fa(input logic [31:0] c);
        return c * 32'h9E3779B1 + 32'h01234567;
    endfunction
    function automatic logic [31:0] fb(input logic [31:0] c);
        return {c[15:0], ~c[15:0]} ^ 32'h0000A5A5;
    endfunction
    function automatic logic [7:0] fch0(input logic [31:0] c);
        int m;
        if (wave_sel == 1) return (c < s1) ? 8'h43 : 8'h91;
        if (wave_sel == 2) return (c < s1) ? 8'hA0 : ((c < s2) ? 8'h60 : 8'hA0);
        m = int'(c % 160);
        return (m < 80) ? 8'(20 + 2 * m) : 8'(20 + 2 * (160 - m));
    endfunction
    function automatic logic [7:0] fch1(input logic [31:0] c);
        return c[7:0] ^ 8'h3C;
    endfunction
    function automatic logic [79:0] frec(input logic [31:0] c);
        return {fb(c), fa(c), fch1(c), fch0(c)};
    endfunction

    always @(negedge clk) begin
        port_a <= fa(cyc);
        port_b <= fb(cyc);
        chan0  <= fch0(cyc);
        chan1  <= fch1(cyc);
    end

    always @(negedge clk) begin
        #1;
        if (mem_we && log_n < LOGMAX) begin
            log_cyc[log_n]  = cyc;
            log_addr[log_n] = mem_addr;
            log_data[log_n] = mem_wdata;
            log_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [79:0] act, input logic [79:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Independent trigger model: index of the firing sample, or -1
    function automatic int model_trig(input logic src, input logic [5:0] pin,
                                      input logic pol, input logic [7:0] arm,
                                      input logic [7:0] fire, input logic [31:0] b,
                                      input int p);
        bit armed = 0;
        for (int k = 0; k < 400; k++) begin
            logic [31:0] c = b + 32'(k * p);
            logic [63:0] lines = {fb(c), fa(c)};
            logic [7:0]  v = fch0(c);
            if (!src) begin
                if (lines[pin] == pol) return k;
            end else if (!armed) begin
                if (v[7:2] <= arm[7:2]) armed = 1;
            end else if (v[7:2] >= fire[7:2]) begin
                return k;
            end
        end
        return -1;
    endfunction

    task automatic start_run(input logic src, input logic [5:0] pin, input logic pol,
                             input logic [7:0] arm, input logic [7:0] fire,
                             input logic [7:0] post, input logic [7:0] w);
        @(negedge clk);
        trig_src = src; trig_pin = pin; trig_pol = pol;
        arm_level = arm; fire_level = fire; post_len = post; extra_wait = w;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        base_cyc = cyc;
        log_n = 0;
        per_p = BASE + int'(w);
        // Scramble the configuration ports mid-capture (R10)
        trig_src = ~src; trig_pin = pin ^ 6'd1; trig_pol = ~pol;
        arm_level = 8'h00; fire_level = 8'hFF; post_len = 8'hFF; extra_wait = 8'd3;
    endtask

    task automatic check_log(input int n);
        int bad_t = 0, bad_a = 0, bad_d = 0, first = -1;
        for (int i = 0; i < n && i < log_n; i++) begin
            logic [31:0] ec = base_cyc + 32'(i * per_p);
            bit bt = (log_cyc[i] != ec);
            bit ba = (log_addr[i] != ADDR_W'(i % DEPTH));
            bit bd = (log_data[i] != frec(ec));
            if ((bt || ba || bd) && first < 0) first = i;
            bad_t += int'(bt); bad_a += int'(ba); bad_d += int'(bd);
        end
        chk(bad_t == 0, "R3", "sample spacing mismatches", 80'(bad_t), 80'(0));
        chk(bad_a == 0, "R5", "write address mismatches", 80'(bad_a), 80'(0));
        chk(bad_d == 0, "R4", "record content mismatches", 80'(bad_d), 80'(0));
        chk(log_n > 0 && log_addr[0] == '0 && log_cyc[0] == base_cyc, "R2",
            "first write cycle after start", 80'(log_cyc[0]), 80'(base_cyc));
    endtask

    task automatic run_case(input string name, input logic src, input logic [5:0] pin,
                            input logic pol, input logic [7:0] arm, input logic [7:0] fire,
                            input logic [7:0] post, input logic [7:0] w);
        int k, exp_n, held_n;
        string ttag;
        start_run(src, pin, pol, arm, fire, post, w);
        k = model_trig(src, pin, pol, arm, fire, base_cyc, per_p);
        ttag = src ? "R7" : "R6";
        for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
        #2;
        exp_n = k + int'(post) + 1;
        $display("[TB] case %s: trigger sample %0d, %0d records", name, k, exp_n);
        chk(k >= 0, ttag, "model finds a trigger", 80'(k), 80'(0));
        chk(done == 1'b1, "R9", "done after post countdown", 80'(done), 80'(1));
        chk(triggered == 1'b1, "R8", "triggered flag", 80'(triggered), 80'(1));
        chk(trig_addr == ADDR_W'(k % DEPTH), ttag, "trigger address",
            80'(trig_addr), 80'(k % DEPTH));
        chk(log_n == exp_n, "R9", "records written", 80'(log_n), 80'(exp_n));
        chk(log_n == exp_n && trig_addr == ADDR_W'(k % DEPTH), "R10",
            "outcome follows latched config", 80'(log_n), 80'(exp_n));
        check_log(exp_n);
        held_n = log_n;
        repeat (3 * per_p) @(negedge clk);
        #2;
        chk(done && log_n == held_n, "R9", "quiet and done while held",
            80'(log_n), 80'(held_n));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        #1;
        chk(!mem_we && !done && !triggered && trig_addr == '0, "R1",
            "outputs during reset", 80'({mem_we, done, triggered}), 80'(0));
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        #2;
        chk(!mem_we && !done && !triggered && trig_addr == '0 && log_n == 0, "R1",
            "idle after reset", 80'(log_n), 80'(0));

        wave_sel = 0;
        run_case("pin5-high",  1'b0, 6'd5,  1'b1, 8'h70, 8'h90, 8'd3, 8'd0);
        run_case("pin40-low",  1'b0, 6'd40, 1'b0, 8'h70, 8'h90, 8'd0, 8'd5);
        run_case("tri-level",  1'b1, 6'd0,  1'b0, 8'h70, 8'h90, 8'd5, 8'd0);
        run_case("tri-slow",   1'b1, 6'd0,  1'b0, 8'h70, 8'h90, 8'd2, 8'd13);

        // Low two bits ignored: 0x43 arms at 0x40, 0x91 fires at 0x93 (R7)
        wave_sel = 1; s1 = cyc + 32'd200;
        run_case("masked-lvl", 1'b1, 6'd0,  1'b0, 8'h40, 8'h93, 8'd1, 8'd3);

        // High before low: must not fire until armed (R7)
        wave_sel = 2; s1 = cyc + 32'd150; s2 = cyc + 32'd400;
        run_case("hysteresis", 1'b1, 6'd0,  1'b0, 8'h70, 8'h90, 8'd2, 8'd1);

        // Line 63 stays low for these cycle numbers: no trigger, wrap (R5, R6)
        wave_sel = 0;
        start_run(1'b0, 6'd63, 1'b1, 8'h70, 8'h90, 8'd0, 8'd0);
        for (int i = 0; i < 2000 && log_n < 20; i++) @(negedge clk);
        #2;
        chk(!triggered && !done, "R6", "no trigger while line inactive",
            80'({triggered, done}), 80'(0));
        chk(log_n == 20, "R5", "capture continues past buffer depth", 80'(log_n), 80'(20));
        check_log(20);

        // Restart mid-gap, trigger at first sample, post wraps the buffer (R2, R5)
        repeat (7) @(negedge clk);
        run_case("restart-wrap", 1'b0, 6'd63, 1'b0, 8'h70, 8'h90, 8'd20, 8'd2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule